// File: doc/BRIEF.md
# Paged Program Counter and Return Stack

This block holds the 10-bit fetch address of a small 14-bit-instruction controller, together with a shallow return stack. Each cycle it takes a control class that the instruction decoder has already worked out. It also takes the instruction's address field, the ALU result, the page bit from the status register and a skip condition. From these it forms the next fetch address.

The upper two address bits are formed separately for each class. Short jumps and short calls, and writes to the PC from a register, take bit 8 from the status page bit instead of from the instruction. Calls push the return address onto the stack. Returns pop it back. A return that carries a literal also presents that literal, with a write strobe, for the working register.

A taken skip does not jump over an address. The PC advances normally and a flush flag is raised for one cycle. During that cycle the already-fetched instruction is treated as a no-operation: its control class is ignored.

Top module: `prog_ctr_stack`

## Requirements
- R1: After reset the fetch address is 000 and the flush flag is low, and every stack entry holds 000, so a return issued straight after reset goes to 000.
- R2: Classes SEQ (code 0), an untaken SKIP (code 1 with the condition low) and the unused codes 9 to 15 all advance the fetch address by one. The address wraps from 3FF to 000.
- R3: SKIP (code 1) with the condition high advances the address by one and raises the flush flag for exactly the following cycle.
- R4: While the flush flag is high, the control class is ignored. The address advances by one, the stack is untouched and the literal strobe stays low.
- R5: PCWR (code 2) loads {0, page bit, ALU result[7:0]}.
- R6: SJMP (code 3) loads {address field bit 9, page bit, address field[7:0]}.
- R7: SCALL (code 4) loads {0, page bit, address field[7:0]} and pushes the current address plus one, wrapped to 10 bits.
- R8: LJMP (code 5) and LCALL (code 6) load the full 10-bit address field. LCALL also pushes the current address plus one.
- R9: RET (code 7) loads the newest stack entry and pops it.
- R10: RETLIT (code 8) behaves as RET. In the same cycle it also drives the literal write strobe high and the literal output with address field[7:0].
- R11: A push onto a full stack (depth 2 by default) discards the oldest entry.
- R12: A pop from an empty stack returns the last entry still held, so repeated pops keep returning the oldest surviving address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctl_i | input | 4 | Decoded control class |
| addr_i | input | 10 | Address or immediate field of the instruction |
| alu_i | input | 8 | ALU result, for PC writes |
| page_i | input | 1 | Page-select bit from the status register |
| skip_cond_i | input | 1 | Skip condition for SKIP |
| pc_o | output | 10 | Fetch address |
| flush_o | output | 1 | Current instruction is to be executed as a no-operation |
| lit_o | output | 8 | Literal for the working register |
| lit_we_o | output | 1 | Working-register load strobe for RETLIT |

## Verification
The bench builds the block with its defaults: a 10-bit address, an 8-bit data path and a stack depth of two. With these defaults a third nested call already overflows the stack, and a third return already underflows it. The wrap from 3FF to 000 is two steps away after one long jump. The random phase therefore repeatedly mixes overflow, underflow, page-bit selection and flushed cycles. A directed prologue pins each of them down first.

// File: rtl/pcs_pkg.sv
package pcs_pkg;
  typedef enum logic [3:0] {
    CTL_SEQ    = 4'd0,
    CTL_SKIP   = 4'd1,
    CTL_PCWR   = 4'd2,
    CTL_SJMP   = 4'd3,
    CTL_SCALL  = 4'd4,
    CTL_LJMP   = 4'd5,
    CTL_LCALL  = 4'd6,
    CTL_RET    = 4'd7,
    CTL_RETLIT = 4'd8
  } pc_ctl_e;

  typedef enum logic [2:0] {
    SRC_INC, SRC_ALU, SRC_SJMP, SRC_SCALL, SRC_FULL, SRC_STACK
  } pc_src_e;
endpackage

// File: rtl/pcs_ctl_dec.sv
module pcs_ctl_dec
  import pcs_pkg::*;
(
  input  logic [3:0] ctl_i,
  input  logic       flush_i,
  input  logic       skip_cond_i,
  output pc_src_e    src_o,
  output logic       push_o,
  output logic       pop_o,
  output logic       flush_set_o,
  output logic       lit_we_o
);
  always_comb begin
    src_o       = SRC_INC;
    push_o      = 1'b0;
    pop_o       = 1'b0;
    flush_set_o = 1'b0;
    lit_we_o    = 1'b0;
    if (!flush_i) begin
      case (ctl_i)
        CTL_SKIP:   flush_set_o = skip_cond_i;
        CTL_PCWR:   src_o = SRC_ALU;
        CTL_SJMP:   src_o = SRC_SJMP;
        CTL_SCALL:  begin src_o = SRC_SCALL; push_o = 1'b1; end
        CTL_LJMP:   src_o = SRC_FULL;
        CTL_LCALL:  begin src_o = SRC_FULL;  push_o = 1'b1; end
        CTL_RET:    begin src_o = SRC_STACK; pop_o  = 1'b1; end
        CTL_RETLIT: begin src_o = SRC_STACK; pop_o  = 1'b1; lit_we_o = 1'b1; end
        default:    src_o = SRC_INC;
      endcase
    end
  end
endmodule

// File: rtl/pcs_next_addr.sv
module pcs_next_addr
  import pcs_pkg::*;
#(
  parameter int PC_W   = 10,
  parameter int DATA_W = 8
) (
  input  pc_src_e           src_i,
  input  logic [PC_W-1:0]   pc_i,
  input  logic [PC_W-1:0]   addr_i,
  input  logic [DATA_W-1:0] alu_i,
  input  logic              page_i,
  input  logic [PC_W-1:0]   stk_top_i,
  output logic [PC_W-1:0]   inc_o,
  output logic [PC_W-1:0]   nxt_o
);
  localparam int HI_W = PC_W - DATA_W; // top bit + page bit

  assign inc_o = pc_i + PC_W'(1);

  always_comb begin
    case (src_i)
      SRC_ALU:   nxt_o = {1'b0, page_i, alu_i};
      SRC_SJMP:  nxt_o = {addr_i[PC_W-1], page_i, addr_i[DATA_W-1:0]};
      SRC_SCALL: nxt_o = {1'b0, page_i, addr_i[DATA_W-1:0]};
      SRC_FULL:  nxt_o = addr_i;
      SRC_STACK: nxt_o = stk_top_i;
      default:   nxt_o = inc_o;
    endcase
  end

  initial begin
    if (HI_W != 2) $error("pcs_next_addr: PC_W must equal DATA_W + 2");
  end
endmodule

// File: rtl/pcs_ret_stack.sv
module pcs_ret_stack #(
  parameter int W     = 10,
  parameter int DEPTH = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic         pop_i,
  input  logic [W-1:0] din_i,
  output logic [W-1:0] top_o
);
  logic [W-1:0] ent_q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic [W-1:0] shin; // value from the entry above on push
    logic [W-1:0] upin; // value from the entry below on pop
    if (i == 0) begin : g_first
      assign shin = din_i;
    end else begin : g_rest
      assign shin = ent_q[i-1];
    end
    if (i == DEPTH-1) begin : g_last
      assign upin = ent_q[i]; // bottom entry sticks on pop
    end else begin : g_mid
      assign upin = ent_q[i+1];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     ent_q[i] <= '0;
      else if (push_i) ent_q[i] <= shin;
      else if (pop_i)  ent_q[i] <= upin;
    end
  end

  assign top_o = ent_q[0];
endmodule

// File: rtl/prog_ctr_stack.sv
module prog_ctr_stack
  import pcs_pkg::*;
#(
  parameter int PC_W    = 10,
  parameter int DATA_W  = 8,
  parameter int STK_DEP = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [3:0]        ctl_i,
  input  logic [PC_W-1:0]   addr_i,
  input  logic [DATA_W-1:0] alu_i,
  input  logic              page_i,
  input  logic              skip_cond_i,
  output logic [PC_W-1:0]   pc_o,
  output logic              flush_o,
  output logic [DATA_W-1:0] lit_o,
  output logic              lit_we_o
);
  logic [PC_W-1:0] pc_q, pc_nxt, pc_inc, stk_top;
  logic            flush_q, flush_set, push, pop;
  pc_src_e         src;

  pcs_ctl_dec u_dec (
    .ctl_i       (ctl_i),
    .flush_i     (flush_q),
    .skip_cond_i (skip_cond_i),
    .src_o       (src),
    .push_o      (push),
    .pop_o       (pop),
    .flush_set_o (flush_set),
    .lit_we_o    (lit_we_o)
  );

  pcs_next_addr #(.PC_W(PC_W), .DATA_W(DATA_W)) u_nxt (
    .src_i     (src),
    .pc_i      (pc_q),
    .addr_i    (addr_i),
    .alu_i     (alu_i),
    .page_i    (page_i),
    .stk_top_i (stk_top),
    .inc_o     (pc_inc),
    .nxt_o     (pc_nxt)
  );

  pcs_ret_stack #(.W(PC_W), .DEPTH(STK_DEP)) u_stk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .push_i (push),
    .pop_i  (pop),
    .din_i  (pc_inc),
    .top_o  (stk_top)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q    <= '0;
      flush_q <= 1'b0;
    end else begin
      pc_q    <= pc_nxt;
      flush_q <= flush_set;
    end
  end

  assign pc_o    = pc_q;
  assign flush_o = flush_q;
  assign lit_o   = addr_i[DATA_W-1:0];
endmodule

// File: rtl/prog_ctr_stack_chk.sv
module prog_ctr_stack_chk #(
  parameter int PC_W   = 10,
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [3:0]        ctl_i,
  input logic [PC_W-1:0]   addr_i,
  input logic [DATA_W-1:0] alu_i,
  input logic              page_i,
  input logic              skip_cond_i,
  input logic [PC_W-1:0]   pc_o,
  input logic              flush_o,
  input logic              lit_we_o
);
  p_reset_r1: assert property (@(posedge clk_i)
    !rst_ni |-> (pc_o == '0 && !flush_o));

  p_seq_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flush_o && ctl_i == 4'd0) |=> pc_o == PC_W'($past(pc_o) + 1'b1));

  p_skip_flush_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flush_o && ctl_i == 4'd1 && skip_cond_i) |=> flush_o);

  p_flush_once_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_o |=> (!flush_o && pc_o == PC_W'($past(pc_o) + 1'b1)));

  p_flush_no_lit_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_o |-> !lit_we_o);

  p_pc_write_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flush_o && ctl_i == 4'd2) |=>
      pc_o == {1'b0, $past(page_i), $past(alu_i)});

  p_long_jump_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flush_o && ctl_i == 4'd5) |=> pc_o == $past(addr_i));

  p_call_ret_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flush_o && ctl_i == 4'd6) ##1 (ctl_i == 4'd7) |=>
      pc_o == PC_W'($past(pc_o, 2) + 1'b1));
endmodule

bind prog_ctr_stack prog_ctr_stack_chk #(.PC_W(PC_W), .DATA_W(DATA_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ctl_i       (ctl_i),
  .addr_i      (addr_i),
  .alu_i       (alu_i),
  .page_i      (page_i),
  .skip_cond_i (skip_cond_i),
  .pc_o        (pc_o),
  .flush_o     (flush_o),
  .lit_we_o    (lit_we_o)
);

// File: tb/prog_ctr_stack_test.sv
module prog_ctr_stack_test;
  localparam int DEP = 2;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [3:0] ctl_i = '0;
  logic [9:0] addr_i = '0;
  logic [7:0] alu_i = '0;
  logic       page_i = 1'b0;
  logic       skip_cond_i = 1'b0;
  logic [9:0] pc_o;
  logic       flush_o;
  logic [7:0] lit_o;
  logic       lit_we_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  // reference state
  int m_pc = 0;
  bit m_fl = 0;
  int m_stk[$];

  always #5 clk_i = ~clk_i;

  prog_ctr_stack uut (.*);

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int m_pop();
    int v = m_stk[0];
    if (m_stk.size() > 1) void'(m_stk.pop_front());
    return v;
  endfunction

  task automatic m_push(input int v);
    m_stk.push_front(v);
    if (m_stk.size() > DEP) void'(m_stk.pop_back());
  endtask

  // one instruction; called just after a falling edge
  task automatic cyc(input string req, input int ctl, input int addr,
                     input int alu, input bit page, input bit cond);
    int nxt;
    bit nfl;
    ctl_i = 4'(ctl); addr_i = 10'(addr); alu_i = 8'(alu);
    page_i = page; skip_cond_i = cond;
    #1;
    chk(req, "lit_we", int'(lit_we_o), int'(!m_fl && ctl == 8));
    if (!m_fl && ctl == 8) chk(req, "lit", int'(lit_o), addr & 'hff);
    nxt = (m_pc + 1) % 1024;
    nfl = 0;
    if (!m_fl) begin
      case (ctl)
        1: nfl = cond;
        2: nxt = (int'(page) << 8) | (alu & 'hff);
        3: nxt = (addr & 'h200) | (int'(page) << 8) | (addr & 'hff);
        4: begin m_push((m_pc + 1) % 1024); nxt = (int'(page) << 8) | (addr & 'hff); end
        5: nxt = addr & 'h3ff;
        6: begin m_push((m_pc + 1) % 1024); nxt = addr & 'h3ff; end
        7, 8: nxt = m_pop();
        default: ;
      endcase
    end
    m_pc = nxt;
    m_fl = nfl;
    @(posedge clk_i);
    @(negedge clk_i);
    chk(req, "pc", int'(pc_o), m_pc);
    chk(req, "flush", int'(flush_o), int'(m_fl));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    for (int i = 0; i < DEP; i++) m_stk.push_back(0);
    repeat (3) @(negedge clk_i);
    chk("R1", "pc", int'(pc_o), 0);
    chk("R1", "flush", int'(flush_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1: stack empty with zeros
    cyc("R1", 7, 0, 0, 0, 0);
    // R2: wrap and unused codes
    cyc("R8", 5, 'h3fe, 0, 0, 0);
    cyc("R2", 0, 0, 0, 0, 0);
    cyc("R2", 0, 0, 0, 0, 0);
    cyc("R2", 12, 'h155, 0, 0, 0);
    cyc("R2", 1, 0, 0, 0, 0);
    // R3/R4: taken skip, then a flushed long jump and a flushed RETLIT
    cyc("R3", 1, 0, 0, 0, 1);
    cyc("R4", 5, 'h2aa, 0, 0, 0);
    cyc("R3", 1, 0, 0, 0, 1);
    cyc("R4", 8, 'h0c3, 0, 0, 0);
    // R5: PC writes with both page values
    cyc("R5", 2, 'h3ff, 'ha5, 1, 0);
    cyc("R5", 2, 'h3ff, 'h5a, 0, 0);
    // R6: short jump, bit 9 from field, bit 8 from page
    cyc("R6", 3, 'h312, 0, 0, 0);
    cyc("R6", 3, 'h0ee, 0, 1, 0);
    // R7/R9: short call then return
    cyc("R7", 4, 'h377, 0, 1, 0);
    cyc("R9", 7, 0, 0, 0, 0);
    // R8/R10: long call then return with literal
    cyc("R8", 6, 'h3c0, 0, 0, 0);
    cyc("R10", 8, 'h03c, 0, 0, 0);
    // R11/R12: three nested calls, four returns
    cyc("R11", 6, 'h100, 0, 0, 0);
    cyc("R11", 6, 'h200, 0, 0, 0);
    cyc("R11", 6, 'h300, 0, 0, 0);
    cyc("R11", 7, 0, 0, 0, 0);
    cyc("R11", 7, 0, 0, 0, 0);
    cyc("R12", 7, 0, 0, 0, 0);
    cyc("R12", 8, 'h0ab, 0, 0, 0);
    // mixed random traffic
    for (int k = 0; k < 2000; k++) begin
      cyc("R2", int'($urandom_range(0, 10)), int'($urandom_range(0, 1023)),
          int'($urandom_range(0, 255)), 1'($urandom), 1'($urandom));
    end
    finish_run();
  end
endmodule